// File: doc/BRIEF.md
# Instruction Length and Structure Decoder

This block scans a window of up to 15 instruction bytes, one byte per clock, and reports how the instruction is built. It reports which legacy prefixes were present, the REX bits when running in 64-bit mode, which opcode map the escape bytes selected, and the opcode byte. It also reports whether a ModR/M byte and a SIB byte follow, the displacement and immediate sizes, and the total length in bytes. A fetch or pre-decode stage loads a window together with a mode bit, pulses `start`, and reads the results when `done` pulses. The results stay valid until the next accepted start. Byte values form a prefix code, so each byte read decides what the walker expects next. Any instruction that would need more than 15 bytes is flagged as too long.

Only a small opcode subset is classified: the one-byte ALU rows, the 0x80/0x81/0x83 ALU-immediate group, the shift group and the unary group. In 32-bit mode the subset also includes the 0x40..0x4F single-byte opcodes. Every opcode reached through an escape, and every other one-byte opcode, is reported as unsupported. In that case the length counts only up to and including the opcode.

The controller is a state machine with these states:
- ST_IDLE waits for `start`.
- ST_PFX consumes legacy prefixes and REX bytes. It leaves on the escape byte 0x0F to ST_ESC, or on an opcode to ST_MODRM (when the opcode takes a ModR/M byte) or to ST_SUM.
- ST_ESC reads the byte after 0x0F. It goes to ST_ESC3 on 0x38 or 0x3A, and otherwise takes that byte as the opcode and goes to ST_SUM.
- ST_ESC3 reads the opcode of a three-byte map and goes to ST_SUM.
- ST_MODRM reads the ModR/M byte and goes to ST_SIB when a SIB byte follows, otherwise to ST_SUM.
- ST_SIB reads the SIB byte and goes to ST_SUM.
- ST_SUM adds displacement and immediate sizes to the bytes consumed, applies the cap, and goes to ST_REPORT.
- ST_REPORT raises `done` for one cycle and returns to ST_IDLE.

Any reading state that finds the 16th byte position goes straight to ST_SUM with the too-long flag set.

Top module: `insn_len_decoder`

## Requirements
- R1: After reset `busy`, `done` and every result output are 0. Byte k of the window is `win[8k+7:8k]`. The window and mode are captured only on a `start` seen in idle, and a `start` while busy is ignored (exactly one `done` per accepted start).
- R2: The prefix flags are set as follows, in any order and with repeats allowed: 0x26/0x2E/0x36/0x3E/0x64/0x65 set `pfx_seg`, 0x66 sets `pfx_opsz`, 0x67 sets `pfx_adsz`, 0xF0 sets `pfx_lock`, 0xF2 sets `pfx_repne`, and 0xF3 sets `pfx_rep`.
- R3: In 64-bit mode a byte 0x40..0x4F is a REX prefix: `rex_valid`=1 and `rex_bits` equals its low nibble (bit 3 is W). The last REX seen wins. A legacy prefix after a REX clears `rex_valid` and `rex_bits`, while a REX before 0x0F is kept. In 32-bit mode 0x40..0x4F is a one-byte opcode of length 1 with no ModR/M byte.
- R4: `opc_map` is 0 for the one-byte map, 1 after 0x0F, 2 after 0x0F 0x38 and 3 after 0x0F 0x3A. `opcode` is the byte after the escapes. Escaped opcodes set `unsupported` and add no operand bytes.
- R5: In the one-byte map the following opcodes are classified:
  - 0x00..0x3F with low bits 0..3 take a ModR/M byte; low bit value 4 takes an 8-bit immediate and low bit value 5 takes a word immediate.
  - 0x80 and 0x83 take ModR/M and imm8, and 0x81 takes ModR/M and a word immediate.
  - 0xC0 and 0xC1 take ModR/M and imm8; 0xD0..0xD3 and 0xFE/0xFF take ModR/M only.
  - Any other one-byte opcode sets `unsupported`, and the length ends at the opcode.
- R6: A word immediate is 4 bytes, or 2 bytes when 0x66 was seen.
- R7: 0xF6 and 0xF7 take ModR/M and carry an immediate (1 byte for 0xF6, a word for 0xF7) only when the ModR/M reg field, bits 5:3, is 000 or 001.
- R8: The ModR/M mod field (bits 7:6) sets the displacement: mod=11 gives no displacement and no SIB byte, mod=01 gives 1 byte, mod=10 gives 4 bytes, and mod=00 gives 4 bytes when rm (bits 2:0) is 101 and 0 bytes otherwise. Byte 0x67 does not change this.
- R9: When mod is not 11 and rm=100, a SIB byte follows. With mod=00 and SIB base (bits 2:0) equal to 101, a 4-byte displacement follows.
- R10: `insn_len` is the total of prefixes, escapes, opcode, ModR/M, SIB, displacement and immediate. If that total exceeds 15, or a needed byte lies at position 15 or beyond, `too_long`=1 and `insn_len`=0.
- R11: `done` is a one-cycle pulse. The results stay unchanged after it until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding the presented window |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| win | input | 120 | Instruction bytes, byte k at bits 8k+7:8k |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle result pulse |
| pfx_seg | output | 1 | Segment override seen |
| pfx_opsz | output | 1 | Operand-size override seen |
| pfx_adsz | output | 1 | Address-size override seen |
| pfx_lock | output | 1 | Lock prefix seen |
| pfx_repne | output | 1 | Repeat-while-not-equal prefix seen |
| pfx_rep | output | 1 | Repeat / repeat-while-equal prefix seen |
| rex_valid | output | 1 | REX prefix in effect |
| rex_bits | output | 4 | REX low nibble (W,R,X,B) |
| opc_map | output | 2 | Opcode map selected by escapes |
| opcode | output | 8 | Opcode byte |
| has_modrm | output | 1 | ModR/M byte present |
| has_sib | output | 1 | SIB byte present |
| disp_bytes | output | 3 | Displacement size in bytes |
| imm_bytes | output | 3 | Immediate size in bytes |
| insn_len | output | 4 | Total length in bytes |
| too_long | output | 1 | Length would exceed 15 bytes |
| unsupported | output | 1 | Opcode outside the classified subset |

## Verification
The length sum and the 15-byte cap both settle in the ST_SUM cycle. There, the operand-size prefix decides whether a word immediate adds 2 or 4 bytes, and that choice alone can tip an instruction over the limit. The bench builds runs of segment prefixes ahead of opcode 0x05, both with and without a 0x66. It sets the runs to land exactly on 15 bytes and one byte past it, and expects a valid length of 15 in the first case and a too-long flag with zero length in the second. Similar pairs place the ModR/M byte or its displacement on the boundary, so the cap raised during the scan and the cap raised by the sum are both exercised.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [1:0] {
        MAP_ONE  = 2'd0,
        MAP_0F   = 2'd1,
        MAP_0F38 = 2'd2,
        MAP_0F3A = 2'd3
    } opmap_e;

    typedef enum logic [3:0] {
        BK_SEG, BK_OPSZ, BK_ADSZ, BK_LOCK, BK_REPNE, BK_REP,
        BK_REX, BK_ESC, BK_OPC
    } bkind_e;

    typedef enum logic [1:0] {
        IMM_NONE, IMM_BYTE, IMM_WORD
    } immk_e;

    typedef struct packed {
        logic  known;
        logic  modrm;
        immk_e imm;
        logic  tgrp;
    } opcls_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PFX, ST_ESC, ST_ESC3, ST_MODRM, ST_SIB, ST_SUM, ST_REPORT
    } ild_state_e;

endpackage

// File: rtl/ild_byte_class.sv
module ild_byte_class
    import ild_pkg::*;
(
    input  logic [7:0] b_in,
    input  logic       mode64,
    output bkind_e     kind
);
    always_comb begin
        case (b_in)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: kind = BK_SEG;
            8'h66:   kind = BK_OPSZ;
            8'h67:   kind = BK_ADSZ;
            8'hF0:   kind = BK_LOCK;
            8'hF2:   kind = BK_REPNE;
            8'hF3:   kind = BK_REP;
            8'h0F:   kind = BK_ESC;
            default: kind = (mode64 && b_in[7:4] == 4'h4) ? BK_REX : BK_OPC;
        endcase
    end
endmodule

// File: rtl/ild_opc_class.sv
module ild_opc_class
    import ild_pkg::*;
(
    input  logic [7:0] b_in,
    input  logic       mode64,
    output opcls_t     cls
);
    always_comb begin
        cls = '{known: 1'b0, modrm: 1'b0, imm: IMM_NONE, tgrp: 1'b0};
        if (b_in[7:6] == 2'b00 && b_in[2:0] <= 3'd5) begin
            cls.known = 1'b1;
            case (b_in[2:0])
                3'd4:    cls.imm = IMM_BYTE;
                3'd5:    cls.imm = IMM_WORD;
                default: cls.modrm = 1'b1;
            endcase
        end else if (b_in[7:4] == 4'h4 && !mode64) begin
            cls.known = 1'b1;
        end else begin
            case (b_in)
                8'h80, 8'h83, 8'hC0, 8'hC1: begin
                    cls.known = 1'b1; cls.modrm = 1'b1; cls.imm = IMM_BYTE;
                end
                8'h81: begin
                    cls.known = 1'b1; cls.modrm = 1'b1; cls.imm = IMM_WORD;
                end
                8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hFE, 8'hFF: begin
                    cls.known = 1'b1; cls.modrm = 1'b1;
                end
                8'hF6: begin
                    cls.known = 1'b1; cls.modrm = 1'b1; cls.imm = IMM_BYTE; cls.tgrp = 1'b1;
                end
                8'hF7: begin
                    cls.known = 1'b1; cls.modrm = 1'b1; cls.imm = IMM_WORD; cls.tgrp = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ild_modrm_dec.sv
module ild_modrm_dec (
    input  logic [1:0] mode_fld,
    input  logic [2:0] rm_fld,
    input  logic [2:0] sib_base,
    output logic       need_sib,
    output logic [2:0] disp
);
    always_comb begin
        need_sib = (mode_fld != 2'b11) && (rm_fld == 3'b100);
        case (mode_fld)
            2'b00:   disp = (rm_fld == 3'b101 ||
                            (rm_fld == 3'b100 && sib_base == 3'b101)) ? 3'd4 : 3'd0;
            2'b01:   disp = 3'd1;
            2'b10:   disp = 3'd4;
            default: disp = 3'd0;
        endcase
    end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter  int MAX_LEN = 15,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int WIN_W   = MAX_LEN * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode64,
    input  logic [WIN_W-1:0] win,
    output logic             busy,
    output logic             done,
    output logic             pfx_seg,
    output logic             pfx_opsz,
    output logic             pfx_adsz,
    output logic             pfx_lock,
    output logic             pfx_repne,
    output logic             pfx_rep,
    output logic             rex_valid,
    output logic [3:0]       rex_bits,
    output logic [1:0]       opc_map,
    output logic [7:0]       opcode,
    output logic             has_modrm,
    output logic             has_sib,
    output logic [2:0]       disp_bytes,
    output logic [2:0]       imm_bytes,
    output logic [LEN_W-1:0] insn_len,
    output logic             too_long,
    output logic             unsupported
);
    localparam int SUM_W = LEN_W + 1;

    ild_state_e       state, nxt;
    logic [WIN_W-1:0] win_q;
    logic             mode_q;
    logic [SUM_W-1:0] pos;
    logic             seg_q, opsz_q, adsz_q, lock_q, repne_q, rep_q;
    logic             rexv_q;
    logic [3:0]       rexb_q;
    opmap_e           map_q;
    logic [7:0]       opc_q;
    logic             mrm_f, sib_f, tgrp_q, tl_q, uns_q;
    logic [1:0]       mrm_mod;
    logic [2:0]       mrm_rm;
    immk_e            immk_q;
    logic [2:0]       disp_q, imm_q;
    logic [LEN_W-1:0] len_q;

    logic [7:0]       wb [2**LEN_W];
    logic [7:0]       cur;
    logic             at_end;
    bkind_e           kind;
    opcls_t           cls;
    logic             need_sib;
    logic [2:0]       dec_disp, imm_n;
    logic [SUM_W-1:0] total;

    for (genvar g = 0; g < 2**LEN_W; g++) begin : g_unpack
        if (g < MAX_LEN) begin : g_byte
            assign wb[g] = win_q[g*8 +: 8];
        end else begin : g_pad
            assign wb[g] = 8'h00;
        end
    end

    assign cur    = wb[pos[LEN_W-1:0]];
    assign at_end = (pos >= SUM_W'(MAX_LEN));

    ild_byte_class u_bcls (.b_in(cur), .mode64(mode_q), .kind(kind));
    ild_opc_class  u_ocls (.b_in(cur), .mode64(mode_q), .cls(cls));
    ild_modrm_dec  u_mdec (
        .mode_fld (state == ST_SIB ? mrm_mod : cur[7:6]),
        .rm_fld   (state == ST_SIB ? mrm_rm  : cur[2:0]),
        .sib_base (cur[2:0]),
        .need_sib (need_sib),
        .disp     (dec_disp)
    );

    always_comb begin
        case (immk_q)
            IMM_BYTE: imm_n = 3'd1;
            IMM_WORD: imm_n = opsz_q ? 3'd2 : 3'd4;
            default:  imm_n = 3'd0;
        endcase
        total = pos + SUM_W'(disp_q) + SUM_W'(imm_n);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_PFX;
            ST_PFX: begin
                if (at_end)                 nxt = ST_SUM;
                else if (kind == BK_ESC)    nxt = ST_ESC;
                else if (kind == BK_OPC)    nxt = (cls.known && cls.modrm) ? ST_MODRM : ST_SUM;
            end
            ST_ESC:    nxt = (!at_end && (cur == 8'h38 || cur == 8'h3A)) ? ST_ESC3 : ST_SUM;
            ST_ESC3:   nxt = ST_SUM;
            ST_MODRM:  nxt = (!at_end && need_sib) ? ST_SIB : ST_SUM;
            ST_SIB:    nxt = ST_SUM;
            ST_SUM:    nxt = ST_REPORT;
            ST_REPORT: nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0; mode_q <= 1'b0; pos <= '0;
            {seg_q, opsz_q, adsz_q, lock_q, repne_q, rep_q} <= '0;
            rexv_q <= 1'b0; rexb_q <= '0; map_q <= MAP_ONE; opc_q <= '0;
            mrm_f <= 1'b0; sib_f <= 1'b0; tgrp_q <= 1'b0; tl_q <= 1'b0; uns_q <= 1'b0;
            mrm_mod <= '0; mrm_rm <= '0; immk_q <= IMM_NONE;
            disp_q <= '0; imm_q <= '0; len_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    win_q <= win; mode_q <= mode64; pos <= '0;
                    {seg_q, opsz_q, adsz_q, lock_q, repne_q, rep_q} <= '0;
                    rexv_q <= 1'b0; rexb_q <= '0; map_q <= MAP_ONE; opc_q <= '0;
                    mrm_f <= 1'b0; sib_f <= 1'b0; tgrp_q <= 1'b0; tl_q <= 1'b0;
                    uns_q <= 1'b0; immk_q <= IMM_NONE;
                    disp_q <= '0; imm_q <= '0; len_q <= '0;
                end
                ST_PFX: if (at_end) tl_q <= 1'b1; else begin
                    pos <= pos + 1'b1;
                    if (kind <= BK_REP) begin rexv_q <= 1'b0; rexb_q <= '0; end
                    case (kind)
                        BK_SEG:   seg_q   <= 1'b1;
                        BK_OPSZ:  opsz_q  <= 1'b1;
                        BK_ADSZ:  adsz_q  <= 1'b1;
                        BK_LOCK:  lock_q  <= 1'b1;
                        BK_REPNE: repne_q <= 1'b1;
                        BK_REP:   rep_q   <= 1'b1;
                        BK_REX:   begin rexv_q <= 1'b1; rexb_q <= cur[3:0]; end
                        BK_ESC:   map_q <= MAP_0F;
                        default: begin
                            opc_q <= cur;
                            if (cls.known) begin
                                mrm_f <= cls.modrm; immk_q <= cls.imm; tgrp_q <= cls.tgrp;
                            end else uns_q <= 1'b1;
                        end
                    endcase
                end
                ST_ESC: if (at_end) tl_q <= 1'b1; else begin
                    pos <= pos + 1'b1;
                    if (cur == 8'h38)      map_q <= MAP_0F38;
                    else if (cur == 8'h3A) map_q <= MAP_0F3A;
                    else begin opc_q <= cur; uns_q <= 1'b1; end
                end
                ST_ESC3: if (at_end) tl_q <= 1'b1; else begin
                    pos <= pos + 1'b1; opc_q <= cur; uns_q <= 1'b1;
                end
                ST_MODRM: if (at_end) tl_q <= 1'b1; else begin
                    pos <= pos + 1'b1;
                    mrm_mod <= cur[7:6]; mrm_rm <= cur[2:0];
                    sib_f <= need_sib;
                    if (!need_sib) disp_q <= dec_disp;
                    if (tgrp_q && cur[5:4] != 2'b00) immk_q <= IMM_NONE;
                end
                ST_SIB: if (at_end) tl_q <= 1'b1; else begin
                    pos <= pos + 1'b1; disp_q <= dec_disp;
                end
                ST_SUM: begin
                    imm_q <= imm_n;
                    if (tl_q || total > SUM_W'(MAX_LEN)) begin
                        tl_q <= 1'b1; len_q <= '0;
                    end else begin
                        len_q <= total[LEN_W-1:0];
                    end
                end
                ST_REPORT: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_REPORT);
        pfx_seg     = seg_q;
        pfx_opsz    = opsz_q;
        pfx_adsz    = adsz_q;
        pfx_lock    = lock_q;
        pfx_repne   = repne_q;
        pfx_rep     = rep_q;
        rex_valid   = rexv_q;
        rex_bits    = rexb_q;
        opc_map     = map_q;
        opcode      = opc_q;
        has_modrm   = mrm_f;
        has_sib     = sib_f;
        disp_bytes  = disp_q;
        imm_bytes   = imm_q;
        insn_len    = len_q;
        too_long    = tl_q;
        unsupported = uns_q;
    end

    AST_TOO_LONG_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && too_long) |-> (insn_len == '0)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(insn_len) && $stable(opcode) && $stable(too_long))); // R11
    AST_SIB_NEEDS_MODRM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && has_sib) |-> has_modrm); // R9
    AST_DISP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_bytes == 3'd0 || disp_bytes == 3'd1 || disp_bytes == 3'd4)); // R8
    AST_REX_MODE64: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rex_valid) |-> mode_q); // R3
    AST_UNSUP_NO_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unsupported) |-> (!has_modrm && disp_bytes == 3'd0 && imm_bytes == 3'd0)); // R4
endmodule

// File: tb/insn_len_decoder_tb_top.sv
`timescale 1ns/1ps
module insn_len_decoder_tb_top;
    localparam int MAXL = 15;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode64 = 1'b0;
    logic [MAXL*8-1:0] win = '0;
    logic busy, done, pfx_seg, pfx_opsz, pfx_adsz, pfx_lock, pfx_repne, pfx_rep;
    logic rex_valid, has_modrm, has_sib, too_long, unsupported;
    logic [3:0] rex_bits, insn_len;
    logic [1:0] opc_map;
    logic [7:0] opcode;
    logic [2:0] disp_bytes, imm_bytes;

    insn_len_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64), .win(win),
        .busy(busy), .done(done), .pfx_seg(pfx_seg), .pfx_opsz(pfx_opsz),
        .pfx_adsz(pfx_adsz), .pfx_lock(pfx_lock), .pfx_repne(pfx_repne),
        .pfx_rep(pfx_rep), .rex_valid(rex_valid), .rex_bits(rex_bits),
        .opc_map(opc_map), .opcode(opcode), .has_modrm(has_modrm),
        .has_sib(has_sib), .disp_bytes(disp_bytes), .imm_bytes(imm_bytes),
        .insn_len(insn_len), .too_long(too_long), .unsupported(unsupported)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [5:0] pfx;   // seg, opsz, adsz, lock, repne, rep
        logic       rexv;
        logic [3:0] rex;
        logic [1:0] map;
        logic [7:0] opc;
        logic       mr;
        logic       sb;
        logic [2:0] disp;
        logic [2:0] imm;
        logic [3:0] len;
        logic       tl;
        logic       uns;
    } res_t;

    res_t  exp_q[$];
    string tag_q[$];
    res_t  last_exp, mon_e;
    string mon_t;
    int    n_chk = 0, n_bad = 0;
    logic [7:0] bbuf [MAXL];
    int    nb = 0;

    function automatic res_t mk(input logic [5:0] p, input logic rv, input logic [3:0] rx,
                                input logic [1:0] mp, input logic [7:0] op, input logic mr,
                                input logic sb, input logic [2:0] dp, input logic [2:0] im,
                                input logic [3:0] ln, input logic tl, input logic un);
        return '{pfx: p, rexv: rv, rex: rx, map: mp, opc: op, mr: mr, sb: sb,
                 disp: dp, imm: im, len: ln, tl: tl, uns: un};
    endfunction

    function automatic res_t act();
        return '{pfx: {pfx_seg, pfx_opsz, pfx_adsz, pfx_lock, pfx_repne, pfx_rep},
                 rexv: rex_valid, rex: rex_bits, map: opc_map, opc: opcode,
                 mr: has_modrm, sb: has_sib, disp: disp_bytes, imm: imm_bytes,
                 len: insn_len, tl: too_long, uns: unsupported};
    endfunction

    task automatic clr();
        for (int i = 0; i < MAXL; i++) bbuf[i] = 8'h00;
        nb = 0;
    endtask

    task automatic b(input logic [7:0] v);
        if (nb < MAXL) bbuf[nb] = v;
        nb++;
    endtask

    task automatic bn(input int n, input logic [7:0] v);
        for (int i = 0; i < n; i++) b(v);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected done: got %h exp none", act());
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (act() !== mon_e) begin
                    n_bad++;
                    $display("FAIL %s: got %h exp %h", mon_t, act(), mon_e);
                end
            end
        end
    end

    // driver: pushes expected item, starts decode, waits for result
    task automatic run(input string tag, input logic m, input res_t e, input bit poke);
        @(negedge clk);
        for (int i = 0; i < MAXL; i++) win[i*8 +: 8] = bbuf[i];
        mode64 = m;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            win = '0;
            win[7:0] = 8'h90;
            mode64 = ~m;
            start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        while (!done) @(negedge clk);
        last_exp = e;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (act() !== '0 || busy !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got %h busy %b exp 0", act(), busy);
        end

        // R5 / R8 register and memory forms
        clr(); b(8'h01); b(8'hC8);
        run("R5 add reg", 0, mk(0,0,0,0,8'h01,1,0,0,0,2,0,0), 0);
        clr(); b(8'h03); b(8'h45); b(8'h10);
        run("R8 mod01 disp8", 0, mk(0,0,0,0,8'h03,1,0,1,0,3,0,0), 0);
        clr(); b(8'h2B); b(8'h05); bn(4, 8'h11);
        run("R8 mod00 rm101", 0, mk(0,0,0,0,8'h2B,1,0,4,0,6,0,0), 0);
        // R9 SIB forms; R1 start while busy ignored on the last one
        clr(); b(8'h01); b(8'h04); b(8'h24);
        run("R9 sib no disp", 0, mk(0,0,0,0,8'h01,1,1,0,0,3,0,0), 0);
        clr(); b(8'h01); b(8'h04); b(8'h25); bn(4, 8'h22);
        run("R9 sib base101", 0, mk(0,0,0,0,8'h01,1,1,4,0,7,0,0), 0);
        clr(); b(8'h01); b(8'h84); b(8'h88); bn(4, 8'h33);
        run("R1 R9 sib disp32 busy-start", 0, mk(0,0,0,0,8'h01,1,1,4,0,7,0,0), 1);
        // R2 / R6 prefixes
        clr(); b(8'h66); b(8'hF0); b(8'hF2); b(8'hF3); b(8'h2E); b(8'h67);
        b(8'h05); b(8'h34); b(8'h12);
        run("R2 R6 all prefixes", 0, mk(6'b111111,0,0,0,8'h05,0,0,0,2,9,0,0), 0);
        clr(); b(8'h3E); b(8'h36); b(8'h26); b(8'h64); b(8'h65); b(8'h04); b(8'h01);
        run("R2 segment set", 0, mk(6'b100000,0,0,0,8'h04,0,0,0,1,7,0,0), 0);
        // R3 REX handling
        clr(); b(8'h48); b(8'h81); b(8'hC0); bn(4, 8'h01);
        run("R3 rex.w imm32", 1, mk(0,1,4'h8,0,8'h81,1,0,0,4,7,0,0), 0);
        clr(); b(8'h41); b(8'h66); b(8'h01); b(8'hC0);
        run("R3 rex dropped", 1, mk(6'b010000,0,0,0,8'h01,1,0,0,0,4,0,0), 0);
        clr(); b(8'h66); b(8'h4C); b(8'h4D); b(8'h01); b(8'hC0);
        run("R3 last rex wins", 1, mk(6'b010000,1,4'hD,0,8'h01,1,0,0,0,5,0,0), 0);
        clr(); b(8'h48);
        run("R3 32-bit 0x48 opcode", 0, mk(0,0,0,0,8'h48,0,0,0,0,1,0,0), 0);
        // R4 escape maps
        clr(); b(8'h0F); b(8'h38); b(8'h00);
        run("R4 map 0F38", 0, mk(0,0,0,2,8'h00,0,0,0,0,3,0,1), 0);
        clr(); b(8'h66); b(8'h0F); b(8'h3A); b(8'h0F);
        run("R4 map 0F3A", 0, mk(6'b010000,0,0,3,8'h0F,0,0,0,0,4,0,1), 0);
        clr(); b(8'h48); b(8'h0F); b(8'hAF);
        run("R4 map 0F rex kept", 1, mk(0,1,4'h8,1,8'hAF,0,0,0,0,3,0,1), 0);
        // R5 shift / group / unsupported
        clr(); b(8'hC1); b(8'hE0); b(8'h04);
        run("R5 shift imm8", 0, mk(0,0,0,0,8'hC1,1,0,0,1,3,0,0), 0);
        clr(); b(8'hD3); b(8'hE0);
        run("R5 shift by count", 0, mk(0,0,0,0,8'hD3,1,0,0,0,2,0,0), 0);
        clr(); b(8'hC0); b(8'h40); b(8'h08); b(8'h05);
        run("R5 R8 shift mem disp8", 0, mk(0,0,0,0,8'hC0,1,0,1,1,4,0,0), 0);
        clr(); b(8'h83); b(8'hC0); b(8'h01);
        run("R5 group 83", 0, mk(0,0,0,0,8'h83,1,0,0,1,3,0,0), 0);
        clr(); b(8'h90);
        run("R5 unsupported", 0, mk(0,0,0,0,8'h90,0,0,0,0,1,0,1), 0);
        // R7 unary group
        clr(); b(8'hF7); b(8'hC0); bn(4, 8'h44);
        run("R7 F7 reg000 imm", 0, mk(0,0,0,0,8'hF7,1,0,0,4,6,0,0), 0);
        clr(); b(8'hF7); b(8'hD8);
        run("R7 F7 reg011 none", 0, mk(0,0,0,0,8'hF7,1,0,0,0,2,0,0), 0);
        clr(); b(8'hF6); b(8'hC8); b(8'h05);
        run("R7 F6 reg001 imm8", 0, mk(0,0,0,0,8'hF6,1,0,0,1,3,0,0), 0);
        clr(); b(8'hFE); b(8'hC0);
        run("R5 FE inc", 0, mk(0,0,0,0,8'hFE,1,0,0,0,2,0,0), 0);
        clr(); b(8'h66); b(8'hF7); b(8'hC0); b(8'h34); b(8'h12);
        run("R6 R7 F7 imm16", 0, mk(6'b010000,0,0,0,8'hF7,1,0,0,2,5,0,0), 0);
        // R10 length cap boundaries
        clr(); b(8'h66); bn(11, 8'h2E); b(8'h05); b(8'h34); b(8'h12);
        run("R10 len 15 with 66", 0, mk(6'b110000,0,0,0,8'h05,0,0,0,2,15,0,0), 0);
        clr(); b(8'h66); bn(12, 8'h2E); b(8'h05); b(8'h34);
        run("R10 len 16 with 66", 0, mk(6'b110000,0,0,0,8'h05,0,0,0,2,0,1,0), 0);
        clr(); bn(10, 8'h2E); b(8'h05); bn(4, 8'h01);
        run("R10 len 15 imm32", 0, mk(6'b100000,0,0,0,8'h05,0,0,0,4,15,0,0), 0);
        clr(); bn(11, 8'h2E); b(8'h05); bn(3, 8'h01);
        run("R10 len 16 imm32", 0, mk(6'b100000,0,0,0,8'h05,0,0,0,4,0,1,0), 0);
        clr(); bn(15, 8'h2E);
        run("R10 all prefixes", 0, mk(6'b100000,0,0,0,8'h00,0,0,0,0,0,1,0), 0);
        clr(); bn(14, 8'h2E); b(8'h01);
        run("R10 modrm off end", 0, mk(6'b100000,0,0,0,8'h01,1,0,0,0,0,1,0), 0);
        clr(); bn(10, 8'h2E); b(8'h01); b(8'h05); bn(3, 8'h00);
        run("R10 disp past cap", 0, mk(6'b100000,0,0,0,8'h01,1,0,4,0,0,1,0), 0);

        // R11 results held after done
        repeat (3) @(negedge clk);
        n_chk++;
        if (act() !== last_exp || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 hold: got %h exp %h", act(), last_exp);
        end
        // R1 no pending or extra results
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 pending: got %0d exp 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule